// File: doc/BRIEF.md
# Message Receive Queue Index Controller

This block keeps the bookkeeping for a circular queue of received messages held in an external, word-addressed message RAM. It does not hold message data itself. It tracks a write position (put index) and an oldest-unread position (get index). From them it forms the RAM word address where the next accepted message is stored and the address of the oldest element. It also keeps a fill count and a set of sticky event flags. The number of queue slots in use (1 up to a compile-time maximum of 64), the payload size code, the RAM base address and a watermark level all come in as configuration inputs.

A source upstream presents one message per cycle on `msg_valid`. When the message is accepted, the block raises `wr_en` in the same cycle and drives `wr_addr`, so the RAM can store it. Software reads elements starting at `rd_addr`. It then reports the index of the last element it consumed through an acknowledge write, and that write moves the get index directly. A mode input selects what happens to a message that arrives while the queue is full. In blocking mode the message is discarded and a lost flag is raised. In overwrite mode the oldest element is replaced and both indices advance.

The configuration inputs `cfg_depth`, `cfg_base` and `cfg_esize` are expected to change only while `rst` is high. The mode and watermark inputs may change at any time.

Top module: `rxq_ctrl`

## Requirements
- R1: After a synchronous reset, both indices are 0, the fill level is 0, `fifo_full` is 0 and all three interrupt flags are 0.
- R2: The element size in RAM words follows `cfg_esize`: code 0 gives 4, 1 gives 5, 2 gives 6, 3 gives 7, 4 gives 8, 5 gives 10, 6 gives 14 and 7 gives 18. `wr_addr` equals `cfg_base + put_idx * size` and `rd_addr` equals `cfg_base + get_idx * size`, modulo 2^AW.
- R3: A message is accepted when `msg_valid` is high and either the queue is not full or overwrite mode is on. `wr_en` is high in that same cycle. After the next edge, `put_idx` has advanced by one and wraps from `cfg_depth-1` to 0.
- R4: When a store makes the put index equal to the get index, `fifo_full` becomes 1 after that edge. `irq_full` is set on the edge where `fifo_full` goes from 0 to 1.
- R5: With `cfg_ovw`=0 and the queue full, an arriving message gives `wr_en`=0 and leaves `put_idx` unchanged, and `irq_lost` is set.
- R6: With `cfg_ovw`=1 and the queue full, an arriving message gives `wr_en`=1, and both `put_idx` and `get_idx` advance by one (with wrap) while `fifo_full` stays 1.
- R7: An acknowledge write (`ack_we`=1) with `ack_idx` < `cfg_depth` sets `get_idx` to `ack_idx`. An acknowledge write with `ack_idx` >= `cfg_depth` leaves `get_idx` unchanged.
- R8: After an accepted acknowledge, `fifo_full` is 0, unless a store in the same cycle brings the new put index equal to the new get index, in which case it is 1.
- R9: `fill_lvl` equals `(put_idx - get_idx) mod cfg_depth` when not full, and `cfg_depth` when full. It is updated on the same edge as the indices.
- R10: `irq_wm` is set on an edge where the fill level goes from below `cfg_wm` to at least `cfg_wm`. A `cfg_wm` of 0 never sets it.
- R11: The flags are sticky. A 1 in bit 0, 1 or 2 of `irq_clr` clears `irq_wm`, `irq_full` or `irq_lost` respectively on the next edge. A set event in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | CW | Number of queue slots in use, 1 to DEPTH_MAX |
| cfg_esize | input | 3 | Payload size code selecting element size |
| cfg_base | input | AW | RAM word address of element 0 |
| cfg_wm | input | CW | Watermark fill level, 0 disables |
| cfg_ovw | input | 1 | 1 selects overwrite mode, 0 selects blocking mode |
| msg_valid | input | 1 | A received message is offered this cycle |
| ack_we | input | 1 | Software acknowledge write strobe |
| ack_idx | input | IW | Index written by the acknowledge |
| irq_clr | input | 3 | Write-one-to-clear for {lost, full, wm} |
| wr_en | output | 1 | Message accepted, store at wr_addr this cycle |
| wr_addr | output | AW | RAM word address for the put index |
| rd_addr | output | AW | RAM word address for the get index |
| put_idx | output | IW | Current put index |
| get_idx | output | IW | Current get index |
| fill_lvl | output | CW | Number of stored elements |
| fifo_full | output | 1 | Queue full status |
| irq_wm | output | 1 | Sticky watermark flag |
| irq_full | output | 1 | Sticky full flag |
| irq_lost | output | 1 | Sticky message-lost flag |

## Verification
A wrong put or get index shows up in the cycle after the faulty edge. It appears on `put_idx`/`get_idx` and on the matching RAM address, because both address outputs are combinational from the index registers. A mistaken full decision has two visible effects. In blocking mode it changes `wr_en` in the same cycle a message is offered. After the edge it changes `fill_lvl` between 0 and the depth. The bench therefore compares every index, address, level and flag against a model on every cycle of a random run, and adds directed wrap, full, overwrite and same-cycle acknowledge cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned ESIZE_W = 3;
  localparam int unsigned WORDS_W = 5;

  // sticky event flags, bit 2 lost, bit 1 full, bit 0 watermark
  typedef struct packed {
    logic lost;
    logic full;
    logic wm;
  } rxq_flags_t;

  function automatic logic [WORDS_W-1:0] elem_words(input logic [ESIZE_W-1:0] code);
    logic [WORDS_W-1:0] w;
    case (code)
      3'd0: w = 5'd4;
      3'd1: w = 5'd5;
      3'd2: w = 5'd6;
      3'd3: w = 5'd7;
      3'd4: w = 5'd8;
      3'd5: w = 5'd10;
      3'd6: w = 5'd14;
      default: w = 5'd18;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/rxq_addr.sv
module rxq_addr #(
  parameter int IW = 6,
  parameter int AW = 16
) (
  input  logic [AW-1:0]                  base,
  input  logic [rxq_pkg::ESIZE_W-1:0]    esize,
  input  logic [IW-1:0]                  idx,
  output logic [AW-1:0]                  addr
);
  logic [AW-1:0] words;

  always_comb begin
    words = AW'(rxq_pkg::elem_words(esize));
    addr  = base + AW'(idx) * words;
  end
endmodule

// File: rtl/rxq_index.sv
module rxq_index #(
  parameter int IW = 6,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_depth,
  input  logic          cfg_ovw,
  input  logic          msg_valid,
  input  logic          ack_we,
  input  logic [IW-1:0] ack_idx,
  output logic          store,
  output logic          drop,
  output logic [IW-1:0] put_q,
  output logic [IW-1:0] get_q,
  output logic          full_q,
  output logic [CW-1:0] fill_q,
  output logic          full_n,
  output logic [CW-1:0] fill_n
);
  logic [IW-1:0] put_n, get_n;
  logic          ack_ok, push_full;

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] i, input logic [CW-1:0] d);
    return ({1'b0, i} == d - CW'(1)) ? '0 : i + IW'(1);
  endfunction

  always_comb begin
    ack_ok    = ack_we && ({1'b0, ack_idx} < cfg_depth);
    store     = msg_valid && (!full_q || cfg_ovw);
    drop      = msg_valid && full_q && !cfg_ovw;
    push_full = store && full_q;
    put_n     = store ? step_idx(put_q, cfg_depth) : put_q;
    if (ack_ok)         get_n = ack_idx;
    else if (push_full) get_n = step_idx(get_q, cfg_depth);
    else                get_n = get_q;
    full_n = (put_n == get_n) && (store || (full_q && !ack_ok));
    if (full_n)                           fill_n = cfg_depth;
    else if ({1'b0, put_n} >= {1'b0, get_n}) fill_n = {1'b0, put_n} - {1'b0, get_n};
    else                                  fill_n = {1'b0, put_n} + cfg_depth - {1'b0, get_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      put_q  <= '0;
      get_q  <= '0;
      full_q <= 1'b0;
      fill_q <= '0;
    end else begin
      put_q  <= put_n;
      get_q  <= get_n;
      full_q <= full_n;
      fill_q <= fill_n;
    end
  end

  assert_put_range_R3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, put_q} < cfg_depth);
  assert_full_match_R4: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (put_q == get_q));
  assert_block_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && full_q && !cfg_ovw && !ack_we) |=> ($stable(put_q) && full_q));
  assert_ovw_stays_full_R6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && full_q && cfg_ovw && !ack_we) |=> full_q);
  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fill_q <= cfg_depth);
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int CW = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       cfg_wm,
  input  logic [CW-1:0]       fill_q,
  input  logic [CW-1:0]       fill_n,
  input  logic                full_q,
  input  logic                full_n,
  input  logic                drop,
  input  logic [2:0]          clr,
  output rxq_pkg::rxq_flags_t flags_q
);
  rxq_pkg::rxq_flags_t set_v, flags_n;

  always_comb begin
    set_v.wm   = (cfg_wm != '0) && (fill_q < cfg_wm) && (fill_n >= cfg_wm);
    set_v.full = full_n && !full_q;
    set_v.lost = drop;
    flags_n    = (flags_q & ~clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_n;
  end

  assert_lost_on_drop_R5: assert property (@(posedge clk) disable iff (rst)
    drop |=> flags_q.lost);
  assert_wm_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wm == '0 && !flags_q.wm) |=> !flags_q.wm);
  assert_full_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (flags_q.full && !clr[1]) |=> flags_q.full);
  assert_lost_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (flags_q.lost && !clr[2]) |=> flags_q.lost);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH_MAX = 64,
  parameter int AW        = 16,
  localparam int IW       = $clog2(DEPTH_MAX),
  localparam int CW       = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_depth,
  input  logic [2:0]    cfg_esize,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_wm,
  input  logic          cfg_ovw,
  input  logic          msg_valid,
  input  logic          ack_we,
  input  logic [IW-1:0] ack_idx,
  input  logic [2:0]    irq_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [IW-1:0] put_idx,
  output logic [IW-1:0] get_idx,
  output logic [CW-1:0] fill_lvl,
  output logic          fifo_full,
  output logic          irq_wm,
  output logic          irq_full,
  output logic          irq_lost
);
  localparam int NPORT = 2;

  logic                store, drop, full_q, full_n;
  logic [IW-1:0]       put_q, get_q;
  logic [CW-1:0]       fill_q, fill_n;
  rxq_pkg::rxq_flags_t flags_q;
  logic [IW-1:0]       idx_sel [NPORT];
  logic [AW-1:0]       addr_v  [NPORT];

  rxq_index #(.IW(IW), .CW(CW)) u_index (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_ovw(cfg_ovw),
    .msg_valid(msg_valid), .ack_we(ack_we), .ack_idx(ack_idx),
    .store(store), .drop(drop), .put_q(put_q), .get_q(get_q),
    .full_q(full_q), .fill_q(fill_q), .full_n(full_n), .fill_n(fill_n)
  );

  rxq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .cfg_wm(cfg_wm), .fill_q(fill_q), .fill_n(fill_n),
    .full_q(full_q), .full_n(full_n), .drop(drop), .clr(irq_clr),
    .flags_q(flags_q)
  );

  assign idx_sel[0] = put_q;
  assign idx_sel[1] = get_q;

  for (genvar g = 0; g < NPORT; g++) begin : g_addr
    rxq_addr #(.IW(IW), .AW(AW)) u_addr (
      .base(cfg_base), .esize(cfg_esize), .idx(idx_sel[g]), .addr(addr_v[g])
    );
  end

  assign wr_en     = store;
  assign wr_addr   = addr_v[0];
  assign rd_addr   = addr_v[1];
  assign put_idx   = put_q;
  assign get_idx   = get_q;
  assign fill_lvl  = fill_q;
  assign fifo_full = full_q;
  assign irq_wm    = flags_q.wm;
  assign irq_full  = flags_q.full;
  assign irq_lost  = flags_q.lost;

  assert_store_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !cfg_ovw) |-> !wr_en);
endmodule

// File: tb/rxq_ctrl_test.sv
module rxq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DMAX = 64;
  localparam int AW = 16;
  localparam int IW = 6;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_depth = 7'd4;
  logic [2:0]    cfg_esize = 3'd0;
  logic [AW-1:0] cfg_base = '0;
  logic [CW-1:0] cfg_wm = '0;
  logic          cfg_ovw = 1'b0;
  logic          msg_valid = 1'b0;
  logic          ack_we = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic [2:0]    irq_clr = '0;
  logic          wr_en, fifo_full, irq_wm, irq_full, irq_lost;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [IW-1:0] put_idx, get_idx;
  logic [CW-1:0] fill_lvl;

  int tests = 0;
  int fails = 0;
  int m_put, m_get, m_fill, m_full, m_wm, m_fl, m_lost;

  rxq_ctrl #(.DEPTH_MAX(DMAX), .AW(AW)) uut (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_esize(cfg_esize),
    .cfg_base(cfg_base), .cfg_wm(cfg_wm), .cfg_ovw(cfg_ovw),
    .msg_valid(msg_valid), .ack_we(ack_we), .ack_idx(ack_idx), .irq_clr(irq_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .put_idx(put_idx),
    .get_idx(get_idx), .fill_lvl(fill_lvl), .fifo_full(fifo_full),
    .irq_wm(irq_wm), .irq_full(irq_full), .irq_lost(irq_lost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int words_of(input int code);
    int tbl[8] = '{4, 5, 6, 7, 8, 10, 14, 18};
    return tbl[code];
  endfunction

  function automatic int addr_of(input int idx);
    return (int'(cfg_base) + idx * words_of(int'(cfg_esize))) % (1 << AW);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state();
    chk("R3", "put_idx", int'(put_idx), m_put);
    chk("R7", "get_idx", int'(get_idx), m_get);
    chk("R4", "fifo_full", int'(fifo_full), m_full);
    chk("R9", "fill_lvl", int'(fill_lvl), m_fill);
    chk("R10", "irq_wm", int'(irq_wm), m_wm);
    chk("R4", "irq_full", int'(irq_full), m_fl);
    chk("R5", "irq_lost", int'(irq_lost), m_lost);
    chk("R2", "rd_addr", int'(rd_addr), addr_of(m_get));
  endtask

  task automatic do_reset(input int depth, input int code, input int base, input int wm, input bit ovw);
    @(negedge clk);
    rst = 1'b1; cfg_depth = CW'(depth); cfg_esize = 3'(code);
    cfg_base = AW'(base); cfg_wm = CW'(wm); cfg_ovw = ovw;
    msg_valid = 0; ack_we = 0; ack_idx = '0; irq_clr = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_put = 0; m_get = 0; m_fill = 0; m_full = 0; m_wm = 0; m_fl = 0; m_lost = 0;
    chk("R1", "reset state", int'({put_idx, get_idx, fill_lvl, fifo_full, irq_wm, irq_full, irq_lost}), 0);
  endtask

  // at a negedge: drive, check same-cycle outputs, update model, advance, check registers
  task automatic step(input bit v, input bit aw, input int ai, input int clr);
    int d, np, ng, nf, nfill;
    bit acc, drp, aok;
    msg_valid = v; ack_we = aw; ack_idx = IW'(ai); irq_clr = 3'(clr);
    #1;
    d = int'(cfg_depth);
    acc = v && (!m_full || cfg_ovw);
    drp = v && m_full && !cfg_ovw;
    aok = aw && (ai < d);
    chk(drp ? "R5" : (m_full ? "R6" : "R3"), "wr_en", int'(wr_en), int'(acc));
    chk("R2", "wr_addr", int'(wr_addr), addr_of(m_put));
    np = acc ? (m_put + 1) % d : m_put;
    if (aok) ng = ai;
    else if (acc && m_full) ng = (m_get + 1) % d;
    else ng = m_get;
    nf = (np == ng) && (acc || (m_full && !aok));
    nfill = nf ? d : (np - ng + d) % d;
    m_wm   = (m_wm && !clr[0]) || (cfg_wm != 0 && m_fill < int'(cfg_wm) && nfill >= int'(cfg_wm));
    m_fl   = (m_fl && !clr[1]) || (nf && !m_full);
    m_lost = (m_lost && !clr[2]) || drp;
    m_put = np; m_get = ng; m_full = nf; m_fill = nfill;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 0; ack_we = 0; irq_clr = '0;
    chk_state();
  endtask

  initial begin
    // directed: depth 4, blocking, watermark 3
    do_reset(4, 2, 'h100, 3, 1'b0);
    chk("R2", "rd_addr after reset", int'(rd_addr), 'h100);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    chk("R4", "full after four stores", int'(fifo_full), 1);
    chk("R10", "watermark flag at level 3", int'(irq_wm), 1);
    step(1, 0, 0, 0);
    chk("R5", "blocked put unchanged", int'(put_idx), 0);
    chk("R5", "lost flag set", int'(irq_lost), 1);
    step(0, 1, 7, 0);
    chk("R7", "out-of-range ack ignored", int'(get_idx), 0);
    chk("R8", "still full after ignored ack", int'(fifo_full), 1);
    step(0, 1, 2, 0);
    chk("R8", "full cleared by ack", int'(fifo_full), 0);
    chk("R9", "fill after ack", int'(fill_lvl), 2);
    step(0, 0, 0, 7);
    chk("R11", "flags cleared", int'({irq_wm, irq_full, irq_lost}), 0);
    step(1, 0, 0, 4);
    chk("R11", "clear without event", int'(irq_lost), 0);
    // overwrite mode
    cfg_ovw = 1'b1;
    step(1, 0, 0, 0);
    chk("R6", "full again", int'(fifo_full), 1);
    step(1, 0, 0, 0);
    chk("R6", "put advanced on overwrite", int'(put_idx), 3);
    chk("R6", "get advanced on overwrite", int'(get_idx), 3);
    step(1, 1, 0, 0);
    chk("R8", "store+ack refills", int'(fifo_full), 1);
    step(1, 1, 2, 0);
    chk("R8", "store+ack not equal clears", int'(fifo_full), 0);
    step(1, 0, 0, 2);
    chk("R11", "set beats clear", int'(irq_full), 1);
    // element size sweep
    for (int c = 0; c < 8; c++) begin
      cfg_esize = 3'(c);
      step(0, 0, 0, 0);
    end
    // depth one, watermark disabled
    do_reset(1, 7, 'hFFF0, 0, 1'b0);
    step(1, 0, 0, 0);
    chk("R4", "depth one full", int'(fifo_full), 1);
    chk("R10", "watermark disabled", int'(irq_wm), 0);
    step(1, 0, 0, 0);
    chk("R5", "depth one lost", int'(irq_lost), 1);
    // depth 64 wrap
    do_reset(64, 6, 'h20, 64, 1'b0);
    for (int i = 0; i < 64; i++) step(1, 0, 0, 0);
    chk("R3", "put wrapped at 64", int'(put_idx), 0);
    chk("R10", "watermark at full depth", int'(irq_wm), 1);
    // random runs
    void'($urandom(32'h5EED_1234));
    for (int r = 0; r < 6; r++) begin
      int d;
      d = 1 + int'($urandom_range(0, DMAX - 1));
      do_reset(d, int'($urandom_range(0, 7)), int'($urandom_range(0, 'hFFFF)),
               int'($urandom_range(0, d)), 1'($urandom_range(0, 1)));
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 31) == 0) cfg_ovw = ~cfg_ovw;
        step(1'($urandom_range(0, 99) < 55), 1'($urandom_range(0, 99) < 20),
             int'($urandom_range(0, DMAX - 1)) % (d + 2),
             ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 7)) : 0);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule